// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked host and an external 128K x 8 asynchronous static RAM. The memory has two chip enables of opposite polarity, an active-low write enable and an active-low output enable. The host offers one read or write at a time with a valid strobe. The controller then plays out the pin sequence for that access, holding each phase for a whole number of clock cycles. Those counts come from the clock period and the memory's minimum timings, and are fixed when the block is elaborated. Read data comes back registered with a single-cycle valid pulse.

The data bus is split into an output value, a drive enable and an input value, so the pad ring can build the tri-state buffer. Before a write the controller keeps output enable high for a turnaround window, so that the memory's output drivers have released the bus before the controller drives it. A level-sensitive standby input deselects the memory whenever the controller has no access in flight. While standby is held, the controller accepts no requests.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and whenever idle, the memory is selected (mem_ce1_n=0, mem_ce2=1) with mem_we_n=1, mem_oe_n=1 and mem_dq_oe=0. In that state busy=0, rd_valid=0 and in_standby=0.
- R2: A request is taken on a rising edge where req_valid=1 and busy=0. A read (req_write=0) holds mem_oe_n low for N_RD cycles and samples mem_dq_i in the last of them. rd_data shows that sample, and rd_valid is high for exactly one cycle, the cycle after the last read cycle. busy is high for the N_RD cycles that follow acceptance.
- R3: A write (req_write=1) runs in three phases. First come N_TURN cycles with mem_oe_n=1, mem_we_n=1 and the driver off. Then come N_WP cycles with mem_we_n=0 and mem_dq_oe=1. Last comes one cycle with mem_we_n=1 and the driver still on. The controller is then idle, so busy lasts N_TURN+N_WP+1 cycles.
- R4: mem_addr and mem_dq_o change only when a request is taken. They stay constant for the whole access, including every cycle with mem_we_n low.
- R5: mem_dq_oe is never high in a cycle where mem_oe_n is low.
- R6: Each wait count is ceil(t_ns*1000/CLK_PERIOD_PS). N_RD covers the larger of cycle time and address access time. N_WP covers the largest of write pulse, enable-to-end, address-to-end and data setup. N_TURN covers output float time. With a 5000 ps clock these give N_RD=14, N_WP=12 and N_TURN=6.
- R7: When standby_req=1 in an idle cycle, the next cycle has in_standby=1, mem_ce1_n=1, mem_ce2=0, mem_we_n=1, mem_oe_n=1 and mem_dq_oe=0.
- R8: busy is high whenever standby_req=1 or in_standby=1. A request offered while in standby causes no write pulse and no rd_valid, and leaves memory contents unchanged.
- R9: If standby_req and req_valid rise in the same idle cycle, standby wins and the request is dropped.
- R10: If standby_req is raised during an access, the access completes normally and standby is entered on the edge after it ends. Releasing standby_req returns the block to idle, with the memory selected, on the next edge.
- R11: A request offered while busy=1 from an access in flight is ignored and does not alter the address or data of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request address |
| req_wdata | input | 8 | Write data |
| standby_req | input | 1 | Level request to deselect the memory |
| busy | output | 1 | Requests are not accepted while high |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 8 | Registered read data |
| in_standby | output | 1 | Memory held deselected |
| mem_addr | output | 17 | Memory address |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Data received from the memory |

## Verification
A standby request and a host request can arrive in the same idle cycle. This is provoked by raising both at the same falling edge. The expected outcome is standby: on the next cycle in_standby is set and the chip enables are released, no write pulse follows, and a later read of the target address still returns the old byte. In a second scenario standby is requested partway through a read. There the bench expects the read data on the normal cycle, with the valid pulse, and in_standby one cycle after it.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_STBY  = 3'd1,
      ST_READ  = 3'd2,
      ST_TURN  = 3'd3,
      ST_PULSE = 3'd4,
      ST_HOLD  = 3'd5
   } ctl_state_e;

   typedef struct packed {
      logic ce1_n;
      logic ce2;
      logic we_n;
      logic oe_n;
      logic dq_oe;
   } pin_ctl_t;

   // whole clock cycles covering a time in ns
   function automatic int ns_to_cycles(input int t_ns, input int period_ps);
      return (t_ns * 1000 + period_ps - 1) / period_ps;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic pin_ctl_t decode_pins(input ctl_state_e s);
      pin_ctl_t p;
      p = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
      case (s)
         ST_STBY: begin
            p.ce1_n = 1'b1;
            p.ce2   = 1'b0;
         end
         ST_READ:  p.oe_n  = 1'b0;
         ST_PULSE: begin
            p.we_n  = 1'b0;
            p.dq_oe = 1'b1;
         end
         ST_HOLD:  p.dq_oe = 1'b1;
         default:  ;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
module sram_ctrl_seq
   import sram_ctrl_pkg::*;
#(
   parameter int CNT_W  = 4,
   parameter int N_RD   = 14,
   parameter int N_TURN = 6,
   parameter int N_WP   = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       req_write,
   input  logic       standby_req,
   output ctl_state_e state_q,
   output ctl_state_e state_d,
   output logic       accept,
   output logic       rd_sample,
   output logic       busy
);

   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d   = state_q;
      cnt_d     = cnt_q;
      accept    = 1'b0;
      rd_sample = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (standby_req) begin
               state_d = ST_STBY;
            end else if (req_valid) begin
               accept  = 1'b1;
               cnt_d   = '0;
               state_d = req_write ? ST_TURN : ST_READ;
            end
         end
         ST_STBY: begin
            if (!standby_req) state_d = ST_IDLE;
         end
         ST_READ: begin
            if (cnt_q == CNT_W'(N_RD - 1)) begin
               rd_sample = 1'b1;
               state_d   = ST_IDLE;
            end else begin
               cnt_d = cnt_q + CNT_W'(1);
            end
         end
         ST_TURN: begin
            if (cnt_q == CNT_W'(N_TURN - 1)) begin
               cnt_d   = '0;
               state_d = ST_PULSE;
            end else begin
               cnt_d = cnt_q + CNT_W'(1);
            end
         end
         ST_PULSE: begin
            if (cnt_q == CNT_W'(N_WP - 1)) begin
               state_d = ST_HOLD;
            end else begin
               cnt_d = cnt_q + CNT_W'(1);
            end
         end
         ST_HOLD: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign busy = (state_q != ST_IDLE) | standby_req;

endmodule

// File: rtl/sram_ctrl_pins.sv
`timescale 1ns/1ps
module sram_ctrl_pins
   import sram_ctrl_pkg::*;
#(
   parameter bit PIN_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  ctl_state_e state_q,
   input  ctl_state_e state_d,
   output pin_ctl_t   pins
);

   generate
      if (PIN_REG) begin : g_flop
         pin_ctl_t pins_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pins_q <= decode_pins(ST_IDLE);
            else        pins_q <= decode_pins(state_d);
         end
         assign pins = pins_q;
      end else begin : g_comb
         assign pins = decode_pins(state_q);
      end
   endgenerate

endmodule

// File: rtl/sram_ctrl_dpath.sv
`timescale 1ns/1ps
module sram_ctrl_dpath #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              rd_sample,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_sample;
         if (rd_sample) rd_data <= mem_dq_i;
      end
   end

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 17,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_PS = 5000,
   parameter int T_RC_NS       = 70,
   parameter int T_WC_NS       = 70,
   parameter int T_AA_NS       = 70,
   parameter int T_WP_NS       = 55,
   parameter int T_CW_NS       = 60,
   parameter int T_AW_NS       = 60,
   parameter int T_DW_NS       = 30,
   parameter int T_HZ_NS       = 30,
   parameter bit PIN_REG       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              standby_req,
   output logic              busy,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              in_standby,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce1_n,
   output logic              mem_ce2,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);

   localparam int N_RD   = max2(ns_to_cycles(T_RC_NS, CLK_PERIOD_PS),
                                ns_to_cycles(T_AA_NS, CLK_PERIOD_PS));
   localparam int N_WP   = max2(max2(ns_to_cycles(T_WP_NS, CLK_PERIOD_PS),
                                     ns_to_cycles(T_CW_NS, CLK_PERIOD_PS)),
                                max2(ns_to_cycles(T_AW_NS, CLK_PERIOD_PS),
                                     ns_to_cycles(T_DW_NS, CLK_PERIOD_PS)));
   localparam int N_TURN = max2(ns_to_cycles(T_HZ_NS, CLK_PERIOD_PS), 1);
   localparam int N_WC   = ns_to_cycles(T_WC_NS, CLK_PERIOD_PS);
   localparam int N_MAX  = max2(max2(N_RD, N_WP), N_TURN);
   localparam int CNT_W  = $clog2(N_MAX + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_ctrl: ADDR_W and DATA_W must be positive");
      end
      if (CLK_PERIOD_PS < 1) begin : g_bad_clk
         $error("sram_ctrl: CLK_PERIOD_PS must be positive");
      end
      if (N_RD < 1 || N_WP < 1) begin : g_bad_count
         $error("sram_ctrl: read and write counts must be at least one cycle");
      end
      if (N_TURN + N_WP + 1 < N_WC) begin : g_bad_wc
         $error("sram_ctrl: write sequence shorter than the write cycle time");
      end
   endgenerate

   ctl_state_e state_q, state_d;
   logic       accept, rd_sample;
   pin_ctl_t   pins;

   sram_ctrl_seq #(
      .CNT_W (CNT_W),
      .N_RD  (N_RD),
      .N_TURN(N_TURN),
      .N_WP  (N_WP)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .standby_req(standby_req),
      .state_q    (state_q),
      .state_d    (state_d),
      .accept     (accept),
      .rd_sample  (rd_sample),
      .busy       (busy)
   );

   sram_ctrl_pins #(
      .PIN_REG(PIN_REG)
   ) u_pins (
      .clk    (clk),
      .rst_n  (rst_n),
      .state_q(state_q),
      .state_d(state_d),
      .pins   (pins)
   );

   sram_ctrl_dpath #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_dpath (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .req_addr (req_addr),
      .req_wdata(req_wdata),
      .rd_sample(rd_sample),
      .mem_dq_i (mem_dq_i),
      .addr_q   (mem_addr),
      .wdata_q  (mem_dq_o),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   assign in_standby = (state_q == ST_STBY);
   assign mem_ce1_n  = pins.ce1_n;
   assign mem_ce2    = pins.ce2;
   assign mem_we_n   = pins.we_n;
   assign mem_oe_n   = pins.oe_n;
   assign mem_dq_oe  = pins.dq_oe;

endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8,
   parameter int N_WP   = 12,
   parameter int N_TURN = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              rd_valid,
   input logic              in_standby,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce1_n,
   input logic              mem_ce2,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [DATA_W-1:0] mem_dq_o,
   input logic              mem_dq_oe
);

   logic [15:0] we_low_cnt;
   logic [15:0] oe_high_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_low_cnt  <= '0;
         oe_high_cnt <= 16'hFFFF;
      end else begin
         we_low_cnt <= mem_we_n ? 16'd0 : we_low_cnt + 16'd1;
         if (!mem_oe_n)                  oe_high_cnt <= '0;
         else if (oe_high_cnt != 16'hFFFF) oe_high_cnt <= oe_high_cnt + 16'd1;
      end
   end

   p_standby_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_standby |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe));

   p_busy_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_standby |-> busy);

   p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_dq_oe && !mem_oe_n));

   p_drive_in_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_dq_oe && mem_oe_n && !mem_ce1_n && mem_ce2));

   p_drive_after_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> mem_dq_oe);

   p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |=> !mem_dq_oe);

   p_turnaround_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> (oe_high_cnt >= 16'(N_TURN)));

   p_pulse_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_low_cnt == 16'(N_WP)));

   p_hold_in_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

   p_rd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

endmodule

bind sram_ctrl sram_ctrl_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .N_WP  (N_WP),
   .N_TURN(N_TURN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .rd_valid  (rd_valid),
   .in_standby(in_standby),
   .mem_addr  (mem_addr),
   .mem_ce1_n (mem_ce1_n),
   .mem_ce2   (mem_ce2),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_dq_o  (mem_dq_o),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_ctrl_tb_top;

   // R6: at 5000 ps per clock, ceil(70/5)=14, ceil(60/5)=12, ceil(30/5)=6
   localparam int EXP_RD   = 14;
   localparam int EXP_WP   = 12;
   localparam int EXP_TURN = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        standby_req = 1'b0;
   logic        busy, rd_valid, in_standby;
   logic [7:0]  rd_data;
   logic [16:0] mem_addr;
   logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [7:0]  mem_dq_o;
   logic [7:0]  mem_dq_i = 8'h5A;

   always #2.5 clk = ~clk;

   sram_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .standby_req(standby_req),
      .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .in_standby(in_standby),
      .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
      .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] ref_mem   [int];
   logic [7:0] model_mem [int];

   function automatic logic [7:0] ref_rd(input int a);
      return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
   endfunction

   function automatic logic [7:0] model_rd(input int a);
      return model_mem.exists(a) ? model_mem[a] : 8'h00;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory pin model and monitors, all at the falling edge
   logic [16:0] prev_addr = '0;
   int          addr_age = 0;
   bit          pend = 1'b0;
   logic [7:0]  pend_d = '0;
   int          we_run = 0;
   int          oe_hi = 1000;
   bit          prev_we = 1'b1;
   int          n_pulses = 0;
   int          err_wp = 0, err_cont = 0, err_turn = 0, err_drv = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_addr == prev_addr) begin
            if (addr_age < 1000) addr_age++;
         end else begin
            addr_age = 0;
         end
         prev_addr = mem_addr;
         if (!mem_ce1_n && mem_ce2 && !mem_we_n) begin
            pend   = 1'b1;
            pend_d = mem_dq_o;
            if (!mem_dq_oe) err_drv++;
         end else if (pend && mem_we_n) begin
            model_mem[int'(mem_addr)] = pend_d;
            pend = 1'b0;
         end
         if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n)
            mem_dq_i = (addr_age >= EXP_RD - 1) ? model_rd(int'(mem_addr))
                                                : ~model_rd(int'(mem_addr));
         else
            mem_dq_i = 8'h5A;
         if (mem_dq_oe && !mem_oe_n) err_cont++;
         if (!mem_we_n) begin
            if (prev_we && oe_hi < EXP_TURN) err_turn++;
            we_run++;
         end else if (we_run != 0) begin
            if (we_run != EXP_WP) err_wp++;
            n_pulses++;
            we_run = 0;
         end
         oe_hi   = mem_oe_n ? ((oe_hi < 1000) ? oe_hi + 1 : oe_hi) : 0;
         prev_we = mem_we_n;
      end
   end

   task automatic do_write(input logic [16:0] a, input logic [7:0] d, input bit poke);
      int bc;
      @(negedge clk);
      while (busy) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      bc = 0;
      while (busy && bc < 100) begin
         bc++;
         if (poke && bc == 3) begin
            req_valid = 1'b1; req_write = ~req_write; req_addr = ~a; req_wdata = ~d;
         end else begin
            req_valid = 1'b0;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      ref_mem[int'(a)] = d;
      chk(bc == EXP_TURN + EXP_WP + 1, "R3 write busy cycles", bc, EXP_TURN + EXP_WP + 1);
   endtask

   task automatic do_read(input logic [16:0] a, input bit poke, input string tag);
      int lat;
      @(negedge clk);
      while (busy) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rd_valid && lat < 100) begin
         if (poke && lat == 4) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = ~a; req_wdata = 8'hEE;
         end else begin
            req_valid = 1'b0;
         end
         @(negedge clk);
         lat++;
      end
      req_valid = 1'b0;
      chk(lat == EXP_RD + 1, "R2 read latency", lat, EXP_RD + 1);
      chk(rd_data == ref_rd(int'(a)), tag, rd_data, ref_rd(int'(a)));
      @(negedge clk);
      chk(!rd_valid, "R2 valid one cycle", rd_valid, 0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         summary();
         $finish;
      end
   end

   initial begin
      int p0;
      logic [16:0] ra;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset / idle state
      chk(!busy && !rd_valid && !in_standby, "R1 reset status", {busy, rd_valid, in_standby}, 0);
      chk(!mem_ce1_n && mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 reset pins",
          {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b01110);

      // directed: address extremes, back-to-back read then write then read
      do_write(17'h00000, 8'hA5, 1'b0);
      do_write(17'h1FFFF, 8'h3C, 1'b0);
      do_read(17'h00000, 1'b0, "R2 read addr 0");
      do_read(17'h1FFFF, 1'b0, "R2 read top addr");
      do_write(17'h1FFFF, 8'hC3, 1'b0);
      do_read(17'h1FFFF, 1'b0, "R3 overwrite read-back");
      // R11 requests during an access
      do_write(17'h00010, 8'h77, 1'b1);
      do_read(17'h00010, 1'b1, "R11 poke during access ignored");
      do_read(~17'h00010, 1'b0, "R11 poke address untouched");

      // R7 / R8 standby entry and ignored request
      @(negedge clk);
      standby_req = 1'b1;
      @(negedge clk);
      chk(busy, "R8 busy with standby_req", busy, 1);
      chk(in_standby, "R7 in_standby", in_standby, 1);
      chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe, "R7 standby pins",
          {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
      p0 = n_pulses;
      req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00000; req_wdata = 8'hFF;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (25) @(negedge clk);
      chk(n_pulses == p0 && !rd_valid, "R8 no write in standby", n_pulses - p0, 0);
      // R10 release
      standby_req = 1'b0;
      @(negedge clk);
      chk(!in_standby && !mem_ce1_n && mem_ce2, "R10 release selects",
          {in_standby, mem_ce1_n, mem_ce2}, 3'b001);
      do_read(17'h00000, 1'b0, "R8 contents kept after standby");

      // R9 standby and request in the same idle cycle
      @(negedge clk);
      p0 = n_pulses;
      standby_req = 1'b1;
      req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h1FFFF; req_wdata = 8'h11;
      @(negedge clk);
      req_valid = 1'b0;
      chk(in_standby, "R9 standby wins", in_standby, 1);
      repeat (25) @(negedge clk);
      chk(n_pulses == p0, "R9 request dropped", n_pulses - p0, 0);
      standby_req = 1'b0;
      do_read(17'h1FFFF, 1'b0, "R9 old data kept");

      // R10 standby requested mid-read
      @(negedge clk);
      while (busy) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00000;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      standby_req = 1'b1;
      repeat (12) @(negedge clk);
      chk(rd_valid && rd_data == ref_rd(0), "R10 read completes", rd_data, ref_rd(0));
      chk(!in_standby, "R10 not yet standby", in_standby, 0);
      @(negedge clk);
      chk(in_standby, "R10 standby after read", in_standby, 1);
      standby_req = 1'b0;
      @(negedge clk);

      // random mix
      for (int i = 0; i < 160; i++) begin
         ra = ($urandom % 2) ? {9'h1FF, 8'($urandom % 16)} : 17'($urandom % 16);
         if ($urandom % 2) do_write(ra, 8'($urandom), 1'($urandom % 4 == 0));
         else              do_read(ra, 1'($urandom % 4 == 0), "R2 random read");
      end

      repeat (4) @(negedge clk);
      chk(err_cont == 0, "R5 bus contention", err_cont, 0);
      chk(err_wp == 0, "R6 write pulse width", err_wp, 0);
      chk(err_turn == 0, "R3 turnaround before write", err_turn, 0);
      chk(err_drv == 0, "R4 driver on during write", err_drv, 0);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule